// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link for a byte-wide non-volatile store. It runs on the system clock. It synchronizes the chip select, serial clock, serial data and pause inputs and finds the serial clock edges itself, so it never clocks from the serial clock. Each frame carries one 8-bit command byte. Address and data bytes may follow. Every field arrives most significant bit first and is sampled on the rising serial clock edge.

The block turns a frame into single-cycle strobes and values for the storage and status logic behind it. Those strobes are write-enable, write-disable, write-byte, write-status and end of frame. Read data, from the array or from the status byte, goes back out serially. The array, the protection rules and the programming timer are outside this block and attach through ports.

Top module: `spife_top`

## Requirements
- R1: The command byte is decoded with bit 3 ignored. Bits 7..4 must be zero, and bits 2..0 select the command: 011 read, 010 write, 110 write-enable, 100 write-disable, 101 read-status, 001 write-status.
- R2: The address follows a read or write command as two bytes, 16 bits sent MSB first. Only the low 13 bits are kept, and they appear on `mem_addr`.
- R3: After a command byte that is not listed in R1, the rest of the frame produces no strobe and `spi_so_oe` stays 0. Once chip select has been high and then low again, a valid command is accepted.
- R4: A read streams array bytes for as long as the frame lasts. The address rises by one after each byte and wraps from 8191 to 0. `spi_si` has no effect once the last address bit has been taken.
- R5: Read-status returns `stat_rdata`, MSB first, and repeats it for every further byte of the frame.
- R6: Each complete data byte of a write gives one `mem_wr_p` pulse, with `wr_byte` and `mem_addr` valid in that cycle. The next address increments only bits 4..0, so it wraps inside its 32-byte page.
- R7: Write-enable and write-disable each give one pulse after the eighth command bit. Write-status gives one `stat_wr_p` pulse carrying the following byte. No two strobes are ever high together.
- R8: `spi_so_oe` is 0 while chip select is high and during command and address bits. The output bit changes after a falling serial clock edge, so it is stable at the next rising edge.
- R9: While the pause input is active, serial clock edges are ignored and `spi_so_oe` is 0. The pause can begin and end only while the serial clock is low. Bit position and shift contents are kept across it.
- R10: `frame_end_p` pulses for one cycle each time chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, idles low, asynchronous |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the tri-state pad of `spi_so` |
| wren_p | output | 1 | Write-enable command strobe |
| wrdi_p | output | 1 | Write-disable command strobe |
| mem_addr | output | 13 | Array address for reads and for writes |
| mem_rdata | input | 8 | Array byte at `mem_addr`, combinational |
| mem_wr_p | output | 1 | Array write-byte strobe |
| wr_byte | output | 8 | Data byte for `mem_wr_p` and `stat_wr_p` |
| stat_rdata | input | 8 | Current status byte |
| stat_wr_p | output | 1 | Status write strobe |
| frame_end_p | output | 1 | Chip select went high |

## Verification
Some rules are checked by assertions on every cycle. These are: the output stays disabled with chip select high and inside a rejected frame, the strobes are mutually exclusive, a page write keeps the upper address bits, the pause only starts or ends with the serial clock low, and the bit counters hold during a pause. Other behaviour can only be shown by the bench's frames. That covers the command decode with the ignored bit, the value of each streamed byte, the address wrap at the top of the array and inside a page, whether serial input is ignored during reads, and whether a transfer resumes correctly after a mid-byte pause.

// File: rtl/spife_pkg.sv
package spife_pkg;

  typedef enum logic [2:0] {
    PH_OP, PH_ADDR, PH_WDATA, PH_RDOUT, PH_SWR, PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    OP_READ, OP_WRITE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_BAD
  } cmd_e;

  // Argument is the command byte with bit 3 removed: {op[7:4], op[2:0]}.
  function automatic cmd_e op_decode(input logic [6:0] op_nx);
    cmd_e c;
    if (op_nx[6:3] != 4'd0) c = OP_BAD;
    else begin
      case (op_nx[2:0])
        3'b011:  c = OP_READ;
        3'b010:  c = OP_WRITE;
        3'b110:  c = OP_WREN;
        3'b100:  c = OP_WRDI;
        3'b101:  c = OP_RDSR;
        3'b001:  c = OP_WRSR;
        default: c = OP_BAD;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/spife_sync.sv
module spife_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign lvl = st[STAGES-1];
endmodule

// File: rtl/spife_hold.sv
module spife_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_lvl,
  input  logic hold_n_lvl,
  output logic hold_act
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        hold_act <= 1'b0;
    else if (!sck_lvl) hold_act <= ~hold_n_lvl;

  logic sck_was;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_was <= 1'b0;
    else        sck_was <= sck_lvl;

  // R9
  hold_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act != $past(hold_act)) |-> !sck_was);
endmodule

// File: rtl/spife_frame.sv
module spife_frame
  import spife_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              sck_lvl,
  input  logic              si_lvl,
  input  logic              hold_act,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        stat_rdata,
  output logic              so_dat,
  output logic              so_oe,
  output logic              wren_p,
  output logic              wrdi_p,
  output logic              mem_wr_p,
  output logic              stat_wr_p,
  output logic [7:0]        wr_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              frame_end_p
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  phase_e            phase;
  logic [2:0]        bcnt, obit;
  logic [6:0]        sh;
  logic [ADDR_W-1:0] addr_sh, addr_q;
  logic              addr_hi, rd_cmd, src_stat;
  logic [7:0]        out_sr;
  logic              sck_prev, cs_prev;

  // edge events seen by the frame logic
  logic sck_rise_g, sck_fall_g, cs_rise;
  logic [7:0] in_byte;
  cmd_e       cmd_now;

  assign sck_rise_g = sck_lvl & ~sck_prev & ~hold_act & ~cs_lvl;
  assign sck_fall_g = ~sck_lvl & sck_prev & ~hold_act & ~cs_lvl;
  assign cs_rise    = cs_lvl & ~cs_prev;
  assign in_byte    = {sh, si_lvl};
  assign cmd_now    = op_decode({in_byte[7:4], in_byte[2:0]});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_prev <= sck_lvl;
      cs_prev  <= cs_lvl;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_OP;
      bcnt        <= '0;
      obit        <= '0;
      sh          <= '0;
      addr_sh     <= '0;
      addr_q      <= '0;
      addr_hi     <= 1'b0;
      rd_cmd      <= 1'b0;
      src_stat    <= 1'b0;
      out_sr      <= '0;
      wren_p      <= 1'b0;
      wrdi_p      <= 1'b0;
      mem_wr_p    <= 1'b0;
      stat_wr_p   <= 1'b0;
      wr_byte     <= '0;
      frame_end_p <= 1'b0;
    end else begin
      wren_p      <= 1'b0;
      wrdi_p      <= 1'b0;
      mem_wr_p    <= 1'b0;
      stat_wr_p   <= 1'b0;
      frame_end_p <= cs_rise;
      if (cs_lvl) begin
        phase   <= PH_OP;
        bcnt    <= '0;
        obit    <= '0;
        addr_hi <= 1'b0;
      end else begin
        if (mem_wr_p) addr_q <= page_next(addr_q);
        if (sck_rise_g) begin
          case (phase)
            PH_OP: begin
              sh   <= in_byte[6:0];
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                case (cmd_now)
                  OP_READ:  begin phase <= PH_ADDR;  rd_cmd <= 1'b1; end
                  OP_WRITE: begin phase <= PH_ADDR;  rd_cmd <= 1'b0; end
                  OP_WREN:  begin phase <= PH_SKIP;  wren_p <= 1'b1; end
                  OP_WRDI:  begin phase <= PH_SKIP;  wrdi_p <= 1'b1; end
                  OP_RDSR:  begin phase <= PH_RDOUT; src_stat <= 1'b1; end
                  OP_WRSR:  phase <= PH_SWR;
                  default:  phase <= PH_SKIP;
                endcase
              end
            end
            PH_ADDR: begin
              addr_sh <= {addr_sh[ADDR_W-2:0], si_lvl};
              bcnt    <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                if (addr_hi) begin
                  addr_q   <= {addr_sh[ADDR_W-2:0], si_lvl};
                  src_stat <= 1'b0;
                  phase    <= rd_cmd ? PH_RDOUT : PH_WDATA;
                end else addr_hi <= 1'b1;
              end
            end
            PH_WDATA: begin
              sh   <= in_byte[6:0];
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                mem_wr_p <= 1'b1;
                wr_byte  <= in_byte;
              end
            end
            PH_SWR: begin
              sh   <= in_byte[6:0];
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                stat_wr_p <= 1'b1;
                wr_byte   <= in_byte;
                phase     <= PH_SKIP;
              end
            end
            default: ;
          endcase
        end
        if (sck_fall_g && phase == PH_RDOUT) begin
          obit <= obit + 3'd1;
          if (obit == 3'd0) begin
            if (src_stat) out_sr <= stat_rdata;
            else begin
              out_sr <= mem_rdata;
              addr_q <= addr_q + 1'b1;
            end
          end else out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end
  end

  assign mem_addr = addr_q;
  assign so_dat   = out_sr[7];
  assign so_oe    = (phase == PH_RDOUT) & ~hold_act;

  // R8
  cs_idle_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> !so_oe);
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_p, wrdi_p, mem_wr_p, stat_wr_p}));
  // R6
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_p |=> mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]));
  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && $past(phase == PH_SKIP))
      |-> !(mem_wr_p || stat_wr_p || wren_p || wrdi_p || so_oe));
  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_lvl) |=> ($stable(bcnt) && $stable(obit)));
  // R10
  fend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_p |=> !frame_end_p);
endmodule

// File: rtl/spife_top.sv
module spife_top #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              wren_p,
  output logic              wrdi_p,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr_p,
  output logic [7:0]        wr_byte,
  input  logic [7:0]        stat_rdata,
  output logic              stat_wr_p,
  output logic              frame_end_p
);
  // bit order: [3] hold_n, [2] si, [1] sck, [0] cs_n
  logic [3:0] pins_lvl;
  logic       hold_act;

  spife_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b1001)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_hold_n, spi_si, spi_sck, spi_cs_n}),
    .lvl(pins_lvl)
  );

  spife_hold i_hold (
    .clk(clk), .rst_n(rst_n),
    .sck_lvl(pins_lvl[1]), .hold_n_lvl(pins_lvl[3]),
    .hold_act(hold_act)
  );

  spife_frame #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(pins_lvl[0]), .sck_lvl(pins_lvl[1]), .si_lvl(pins_lvl[2]),
    .hold_act(hold_act),
    .mem_rdata(mem_rdata), .stat_rdata(stat_rdata),
    .so_dat(spi_so), .so_oe(spi_so_oe),
    .wren_p(wren_p), .wrdi_p(wrdi_p),
    .mem_wr_p(mem_wr_p), .stat_wr_p(stat_wr_p),
    .wr_byte(wr_byte), .mem_addr(mem_addr),
    .frame_end_p(frame_end_p)
  );
endmodule

// File: tb/test_spife_top.sv
module test_spife_top;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic spi_so, spi_so_oe, wren_p, wrdi_p, mem_wr_p, stat_wr_p, frame_end_p;
  logic [12:0] mem_addr;
  logic [7:0]  mem_rdata, wr_byte;
  logic [7:0]  stat_val = 8'h00;

  int n_chk = 0, n_bad = 0;
  int wr_n = 0, wren_n = 0, wrdi_n = 0, swr_n = 0, fend_n = 0, frames = 0;
  logic [12:0] wr_a [64];
  logic [7:0]  wr_d [64];
  logic [7:0]  swr_last = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [12:0] a);
    return (a[7:0] * 8'd37) ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction
  function automatic logic [12:0] rd_addr(input logic [12:0] a, input int i);
    return 13'((int'(a) + i) % 8192);
  endfunction
  function automatic logic [12:0] pg_addr(input logic [12:0] a, input int i);
    return {a[12:5], 5'((int'(a[4:0]) + i) % 32)};
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  spife_top i_spife_top (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so),
    .spi_so_oe(spi_so_oe), .wren_p(wren_p), .wrdi_p(wrdi_p),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wr_p(mem_wr_p),
    .wr_byte(wr_byte), .stat_rdata(stat_val), .stat_wr_p(stat_wr_p),
    .frame_end_p(frame_end_p)
  );

  always @(negedge clk) if (rst_n) begin
    if (mem_wr_p) begin
      if (wr_n < 64) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = wr_byte; end
      wr_n++;
    end
    if (wren_p) wren_n++;
    if (wrdi_p) wrdi_n++;
    if (stat_wr_p) begin swr_n++; swr_last = wr_byte; end
    if (frame_end_p) fend_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one byte; samples spi_so before each rising edge; optional pause at bit hold_bit
  task automatic xbyte(input logic [7:0] tx, input bit exp_oe, input int hold_bit,
                       output logic [7:0] rx, output bit oe_ok);
    oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      spi_si = tx[i];
      wt(HALF);
      if (i == hold_bit) begin
        spi_hold_n = 1'b0;
        wt(HALF);
        check(spi_so_oe == 1'b0, "R9 pause so_oe", spi_so_oe, 0);
        for (int k = 0; k < 3; k++) begin
          spi_si = 1'($urandom);
          spi_sck = 1'b1; wt(HALF);
          spi_sck = 1'b0; wt(HALF);
        end
        check(spi_so_oe == 1'b0, "R9 pause after clocks", spi_so_oe, 0);
        spi_si = tx[i];
        spi_hold_n = 1'b1;
        wt(HALF);
      end
      rx[i] = spi_so;
      if (spi_so_oe !== exp_oe) oe_ok = 1'b0;
      spi_sck = 1'b1; wt(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic fbegin();
    spi_cs_n = 1'b0; wt(HALF);
  endtask
  task automatic fend();
    wt(HALF); spi_cs_n = 1'b1; wt(10);
    frames++;
    check(spi_so_oe == 1'b0, "R8 so_oe with cs high", spi_so_oe, 0);
    check(fend_n == frames, "R10 frame end count", fend_n, frames);
  endtask

  task automatic send_cmd(input logic [7:0] op);
    logic [7:0] r; bit ok;
    xbyte(op, 1'b0, -1, r, ok);
    check(ok, "R8 so_oe low during command", 0, 0);
  endtask

  task automatic send_addr(input logic [15:0] a);
    logic [7:0] r; bit ok1, ok2;
    xbyte(a[15:8], 1'b0, -1, r, ok1);
    xbyte(a[7:0],  1'b0, -1, r, ok2);
    check(ok1 && ok2, "R8 so_oe low during address", 0, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input int len, input int hold_byte);
    logic [7:0] r; bit ok;
    fbegin(); send_cmd(($urandom % 2) ? 8'h0B : 8'h03); send_addr(a);
    for (int i = 0; i < len; i++) begin
      xbyte(8'($urandom), 1'b1, (i == hold_byte) ? 3 : -1, r, ok);
      check(r == mem_fn(rd_addr(a[12:0], i)), "R4 R2 read byte", r, mem_fn(rd_addr(a[12:0], i)));
      check(ok, "R8 so_oe during read", 0, 1);
    end
    fend();
  endtask

  task automatic do_write(input logic [15:0] a, input int len);
    logic [7:0] r; bit ok; int base;
    logic [7:0] d [8];
    base = wr_n;
    fbegin(); send_cmd(($urandom % 2) ? 8'h0A : 8'h02); send_addr(a);
    for (int i = 0; i < len; i++) begin
      d[i] = 8'($urandom);
      xbyte(d[i], 1'b0, -1, r, ok);
    end
    fend();
    check(wr_n == base + len, "R6 write strobe count", wr_n, base + len);
    for (int i = 0; i < len; i++) begin
      check(wr_a[base+i] == pg_addr(a[12:0], i), "R6 R2 write address",
            wr_a[base+i], pg_addr(a[12:0], i));
      check(wr_d[base+i] == d[i], "R6 write data", wr_d[base+i], d[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; bit ok; int w0, s0;
    void'($urandom(32'd4242));
    wt(5);
    check(spi_so_oe == 1'b0, "R8 reset so_oe", spi_so_oe, 0);
    check({wren_p, wrdi_p, mem_wr_p, stat_wr_p} == 4'b0, "R7 reset strobes",
          {wren_p, wrdi_p, mem_wr_p, stat_wr_p}, 0);
    rst_n = 1'b1; wt(5);

    // R1 R7: enable / disable, both values of the ignored bit
    foreach (r[i]) ;
    fbegin(); send_cmd(8'h06); fend();
    check(wren_n == 1, "R1 R7 enable 06", wren_n, 1);
    fbegin(); send_cmd(8'h0E); fend();
    check(wren_n == 2, "R1 R7 enable 0E", wren_n, 2);
    fbegin(); send_cmd(8'h0C); fend();
    check(wrdi_n == 1, "R1 R7 disable 0C", wrdi_n, 1);
    fbegin(); send_cmd(8'h04); fend();
    check(wrdi_n == 2, "R1 R7 disable 04", wrdi_n, 2);

    // R7: status write
    for (int t = 0; t < 3; t++) begin
      logic [7:0] v;
      v = 8'($urandom);
      fbegin(); send_cmd(t[0] ? 8'h09 : 8'h01);
      xbyte(v, 1'b0, -1, r, ok);
      fend();
      check(swr_n == t + 1 && swr_last == v, "R7 status write byte", swr_last, v);
    end

    // R5: status read, repeated
    for (int t = 0; t < 2; t++) begin
      stat_val = 8'($urandom);
      fbegin(); send_cmd(t[0] ? 8'h0D : 8'h05);
      for (int b = 0; b < 3; b++) begin
        xbyte(8'($urandom), 1'b1, -1, r, ok);
        check(r == stat_val && ok, "R5 status read", r, stat_val);
      end
      fend();
    end

    // R2 R4: random reads, upper address bits random
    for (int t = 0; t < 5; t++) do_read(16'($urandom), 2 + t % 3, -1);
    // R4: wrap at top of array
    do_read(16'hFFFE, 4, -1);
    do_read(16'h1FFF, 2, -1);

    // R6: writes, random and across page end
    for (int t = 0; t < 3; t++) do_write(16'($urandom), 1 + t);
    do_write(16'h003E, 3);
    do_write(16'hE01F, 2);

    // R3: rejected commands, followed by more bytes
    w0 = wr_n; s0 = swr_n;
    foreach (r[i]) ;
    for (int t = 0; t < 3; t++) begin
      logic [7:0] bad;
      bad = (t == 0) ? 8'h07 : (t == 1) ? 8'h13 : 8'h00;
      fbegin(); send_cmd(bad);
      for (int b = 0; b < 3; b++) begin
        xbyte(8'h03, 1'b0, -1, r, ok);
        check(ok, "R3 so_oe low after bad command", 1, 0);
      end
      fend();
    end
    check(wr_n == w0 && swr_n == s0 && wren_n == 2 && wrdi_n == 2,
          "R3 no strobes after bad command", wr_n - w0 + swr_n - s0, 0);
    do_read(16'h0123, 2, -1);

    // R9: pause in the middle of a read byte
    do_read(16'h0456, 3, 1);
    do_read(16'h1FFF, 2, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule